// File: doc/BRIEF.md
# Wired-to-Message Interrupt Translator

This block watches a bank of wired interrupt lines and converts each triggering event into a single message-signalled interrupt write. Software configures each line in two ways. It picks the trigger kind: level-high or rising-edge. It also sets a per-line vector word that holds an event identifier and a device identifier. When a line fires, the block latches a status bit for that line. It then queues the line for transmission. A round-robin arbiter picks one queued line at a time and presents a write on a valid/ready port. The write goes to a doorbell address that is fixed by parameter, and its data carries the line's identifiers.

The status bit stops repeated messages from the same line. While it is set, a level-high line stays silent. A rising edge that arrives in that period is remembered and sent once the status is cleared. Software clears status by writing ones into a separate clear window. That window is indexed by the global line number minus the reserved count, with no per-node split. A single node of lines is implemented, and its index is a parameter.

Top module: `irq_msg_bridge`

## Requirements
- R1: The vector word of local line p is at byte address NODE_IDX*0x1000 + 0x200 + 4*p. Bits [11:0] hold the device ID and bits [21:12] hold the event ID. Bits [31:22] are discarded on write and read back as zero. A read returns data on `bus_rdata` one clock after `bus_rd`.
- R2: The trigger kinds of the lines are packed 32 per word at byte address NODE_IDX*0x1000 + 4*(p/32), bit p%32. A 1 selects level-high and a 0 selects rising-edge. All 32 bits of each word read back as written.
- R3: In rising-edge mode, a 0-to-1 change of a line with clear status produces exactly one write. Its address is DOORBELL and its data is {10'b0, event ID, device ID}. A line that stays high produces no further write.
- R4: In level-high mode, a high line produces one write and then stays silent while its status is set. After a clear, if the line is still high, one new write follows.
- R5: A rising edge seen while status is set is held. Exactly one write for it follows the clear, and none before.
- R6: Status of local line p clears only when a 1 is written to bit g%32 of byte address 0xA000 + 4*(g/32), where g = (NODE_IDX-1)*NUM_PINS + p. Zero bits and words that belong to other nodes have no effect.
- R7: Among queued lines, the grant goes to the lowest-numbered queued line at or above (last granted + 1), wrapping around past the top line. After reset the search starts at line 0.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R9: After reset, `msg_valid` and `bus_rdata` are 0 and every trigger-kind bit is 0 (rising-edge).
- R10: With the output idle, suppose a line's rise is first sampled at clock edge k. Then `msg_valid` is high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_PINS | Wired interrupt lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | MSG_ADDR_W | Doorbell address |
| msg_data | output | 32 | {10'b0, event ID, device ID} |

## Verification
The register space is swept completely. All 128 vector words are written with garbage in the upper bits and then read back. The trigger-kind words are filled with dense bit patterns. Each of the 128 lines is fired in turn in edge mode, which separates wrong vector lookup, wrong latency and repeated sending. One line is then driven through edge-while-pending, wrong-bit clears and foreign-node clears, which separates the held-edge memory from a plain clear decoder. A level line is kept high across a clear to show the re-send. Three lines fired together with the output stalled show the wrap-around grant order and the hold of a stalled message.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int WORD_W        = 32;
  localparam int EVT_W         = 10;
  localparam int DEV_W         = 12;
  localparam int VEC_W         = EVT_W + DEV_W;
  localparam int PINS_PER_WORD = 32;
  localparam int NODE_SPAN     = 'h1000;
  localparam int VEC_OFFSET    = 'h0200;
  localparam int CLR_BASE      = 'hA000;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [DEV_W-1:0] dev;
  } vec_t;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_pin_trigger.sv
module irq_pin_trigger
  import irq_msg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_in,
  input  trig_e mode,
  input  logic  clr,
  input  logic  take,
  output logic  pend
);
  logic pin_q;
  logic status;
  logic edge_held;
  logic rise;
  logic fire;

  assign rise = pin_in & ~pin_q;

  always_comb begin
    if (mode == TRIG_LEVEL) fire = pin_in;
    else                    fire = rise | edge_held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q     <= 1'b0;
      status    <= 1'b0;
      edge_held <= 1'b0;
      pend      <= 1'b0;
    end else begin
      pin_q <= pin_in;
      if (take) pend <= 1'b0;
      if (clr) begin
        status <= 1'b0;
        if (mode == TRIG_EDGE && rise) edge_held <= 1'b1;
      end else if (!status && fire) begin
        status    <= 1'b1;
        pend      <= 1'b1;
        edge_held <= 1'b0;
      end else if (status && mode == TRIG_EDGE && rise) begin
        edge_held <= 1'b1;
      end
    end
  end

  // R4: status persists until an explicit clear
  assert_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (status && !clr) |=> status);

  // R3: every new status event queues exactly one message
  assert_status_queues_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> pend);

  // R5: a held edge fires as soon as status is free
  assert_edge_replay_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && edge_held && !status && !clr) |=> status);
endmodule

// File: rtl/irq_rr_arbiter.sv
module irq_rr_arbiter #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr;
  int j;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    j         = 0;
    for (int i = 0; i < N; i++) begin
      j = (int'(ptr) + i) % N;
      if (!gnt_valid && req[j]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance && gnt_valid) begin
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end
  end

  // R7: a grant is only issued while some line is queued
  assert_grant_has_req_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && gnt_valid) |-> (req != '0));
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int NODE_IDX = 1,
  localparam int IDX_W      = $clog2(NUM_PINS),
  localparam int TYPE_WORDS = NUM_PINS / PINS_PER_WORD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [15:0]         bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] type_bits,
  output logic [NUM_PINS-1:0] clr_bits,
  input  logic [IDX_W-1:0]    vec_idx,
  output vec_t                vec_out
);
  localparam int NODE_BASE = NODE_IDX * NODE_SPAN;
  localparam int TYPE_LO   = NODE_BASE;
  localparam int TYPE_HI   = TYPE_LO + 4 * TYPE_WORDS;
  localparam int VEC_LO    = NODE_BASE + VEC_OFFSET;
  localparam int VEC_HI    = VEC_LO + 4 * NUM_PINS;
  localparam int CLR_LO    = CLR_BASE + 4 * TYPE_WORDS * (NODE_IDX - 1);
  localparam int CLR_HI    = CLR_LO + 4 * TYPE_WORDS;

  vec_t vec_mem [NUM_PINS];

  int a;
  logic is_type, is_vec, is_clr;
  int type_w, clr_w;
  logic [IDX_W-1:0] vec_sel;

  always_comb begin
    a       = {16'b0, bus_addr};
    is_type = (bus_addr[1:0] == 2'b00) && (a >= TYPE_LO) && (a < TYPE_HI);
    is_vec  = (bus_addr[1:0] == 2'b00) && (a >= VEC_LO)  && (a < VEC_HI);
    is_clr  = (bus_addr[1:0] == 2'b00) && (a >= CLR_LO)  && (a < CLR_HI);
    type_w  = (a - TYPE_LO) >>> 2;
    clr_w   = (a - CLR_LO) >>> 2;
    vec_sel = IDX_W'((a - VEC_LO) >>> 2);
  end

  always_comb begin
    clr_bits = '0;
    for (int w = 0; w < TYPE_WORDS; w++) begin
      if (bus_wr && is_clr && clr_w == w)
        clr_bits[w*PINS_PER_WORD +: PINS_PER_WORD] = bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_bits <= '0;
    end else begin
      for (int w = 0; w < TYPE_WORDS; w++) begin
        if (bus_wr && is_type && type_w == w)
          type_bits[w*PINS_PER_WORD +: PINS_PER_WORD] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && is_vec) vec_mem[vec_sel] <= vec_t'(bus_wdata[VEC_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (is_vec) bus_rdata <= {{(WORD_W-VEC_W){1'b0}}, vec_mem[vec_sel]};
      for (int w = 0; w < TYPE_WORDS; w++) begin
        if (is_type && type_w == w)
          bus_rdata <= type_bits[w*PINS_PER_WORD +: PINS_PER_WORD];
      end
    end
  end

  assign vec_out = vec_mem[vec_idx];

  // R6: clear pulses come only from a bus write
  assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |-> bus_wr);
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS   = 128,
  parameter int NODE_IDX   = 1,
  parameter int MSG_ADDR_W = 32,
  parameter logic [MSG_ADDR_W-1:0] DOORBELL = 32'hFEE0_1040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pins_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [15:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [MSG_ADDR_W-1:0] msg_addr,
  output logic [31:0]           msg_data
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] type_bits;
  logic [NUM_PINS-1:0] clr_bits;
  logic [NUM_PINS-1:0] pend_vec;
  logic [NUM_PINS-1:0] take_vec;
  logic                gnt_valid;
  logic [IDX_W-1:0]    gnt_idx;
  logic                load;
  vec_t                gnt_vec;

  assign load = gnt_valid && (!msg_valid || msg_ready);

  irq_reg_file #(.NUM_PINS(NUM_PINS), .NODE_IDX(NODE_IDX)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .type_bits(type_bits),
    .clr_bits(clr_bits), .vec_idx(gnt_idx), .vec_out(gnt_vec)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign take_vec[i] = load && (gnt_idx == IDX_W'(i));
    irq_pin_trigger u_trig (
      .clk(clk), .rst(rst), .pin_in(pins_in[i]), .mode(trig_e'(type_bits[i])),
      .clr(clr_bits[i]), .take(take_vec[i]), .pend(pend_vec[i])
    );
  end

  irq_rr_arbiter #(.N(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(pend_vec), .advance(load),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= DOORBELL;
      msg_data  <= {{(32-VEC_W){1'b0}}, gnt_vec};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R8: a stalled message does not change
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr)));

  // R7: at most one line is dequeued per cycle
  assert_single_take_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_vec));

  // R8: nothing is dequeued while the output is stalled
  assert_no_take_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |-> (take_vec == '0));
endmodule

// File: tb/irq_msg_bridge_bench.sv
module irq_msg_bridge_bench;
  localparam int NP = 128;
  localparam logic [31:0] DB = 32'hFEE0_1040;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins_in = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [31:0]   msg_addr;
  logic [31:0]   msg_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_msg_bridge #(.NUM_PINS(NP), .NODE_IDX(1), .MSG_ADDR_W(32), .DOORBELL(DB)) u_irq_msg_bridge (
    .clk(clk), .rst(rst), .pins_in(pins_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] vec_word(int p);
    logic [31:0] ev, dv;
    ev = 32'((p * 37 + 5) & 'h3FF);
    dv = 32'((p * 11 + 3) & 'hFFF);
    return 32'hFFC0_0000 | (ev << 12) | dv;
  endfunction

  function automatic logic [31:0] exp_data(int p);
    return vec_word(p) & 32'h003F_FFFF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clear_pin(input int p);
    bus_write(16'(32'hA000 + 4 * (p / 32)), 32'(1) << (p % 32));
  endtask

  task automatic wait_msg(input int p, input string req);
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    check(seen && msg_data == exp_data(p) && msg_addr == DB, req,
          {31'(0), seen, msg_data}, {32'(1), exp_data(p)});
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!msg_valid, req, 64'(msg_valid), 64'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check(!msg_valid, "R9 valid", 64'(msg_valid), 0);
    check(bus_rdata == 0, "R9 rdata", 64'(bus_rdata), 0);
    for (int w = 0; w < 4; w++) begin
      bus_read(16'(32'h1000 + 4 * w), d);
      check(d == 0, "R9 type reset", 64'(d), 0);
    end

    // R1 vector sweep
    for (int p = 0; p < NP; p++) bus_write(16'(32'h1200 + 4 * p), vec_word(p));
    for (int p = 0; p < NP; p++) begin
      bus_read(16'(32'h1200 + 4 * p), d);
      check(d == exp_data(p), "R1 vector readback", 64'(d), 64'(exp_data(p)));
    end

    // R2 trigger-kind words
    for (int w = 0; w < 4; w++) bus_write(16'(32'h1000 + 4 * w), 32'hA5C3_0F96 ^ (32'h1111_1111 * w));
    for (int w = 0; w < 4; w++) begin
      bus_read(16'(32'h1000 + 4 * w), d);
      check(d == (32'hA5C3_0F96 ^ (32'h1111_1111 * w)), "R2 type readback",
            64'(d), 64'(32'hA5C3_0F96 ^ (32'h1111_1111 * w)));
    end
    for (int w = 0; w < 4; w++) bus_write(16'(32'h1000 + 4 * w), 32'h0);

    // R3 / R10 edge sweep over every line
    for (int p = 0; p < NP; p++) begin
      pins_in[p] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(msg_valid && msg_data == exp_data(p) && msg_addr == DB, "R10 R3 edge message",
            {31'(0), msg_valid, msg_data}, {32'(1), exp_data(p)});
      expect_quiet(2, "R3 no repeat while high");
      pins_in[p] = 1'b0;
      clear_pin(p);
    end
    expect_quiet(3, "R3 quiet after clears");

    // R5 / R6 held edge and clear decoding on line 7
    pins_in[7] = 1'b1;
    wait_msg(7, "R3 line 7 first");
    pins_in[7] = 1'b0;
    @(negedge clk);
    pins_in[7] = 1'b1;
    expect_quiet(5, "R5 no send while status set");
    bus_write(16'hA000, ~(32'(1) << 7));
    expect_quiet(4, "R6 zero bit ignored");
    bus_write(16'hA010, 32'hFFFF_FFFF);
    expect_quiet(4, "R6 other node ignored");
    clear_pin(7);
    wait_msg(7, "R5 held edge sent after clear");
    expect_quiet(6, "R5 held edge sent once");
    pins_in[7] = 1'b0;
    clear_pin(7);

    // R4 level line 40
    bus_write(16'h1004, 32'(1) << 8);
    pins_in[40] = 1'b1;
    wait_msg(40, "R4 level first");
    expect_quiet(8, "R4 level silent while set");
    clear_pin(40);
    wait_msg(40, "R4 level resend after clear");
    expect_quiet(4, "R4 single resend");
    pins_in[40] = 1'b0;
    clear_pin(40);
    expect_quiet(4, "R4 low after clear stays quiet");

    // R7 / R8 round robin from pointer 41 with stalled output
    msg_ready = 1'b0;
    pins_in[3] = 1'b1; pins_in[50] = 1'b1; pins_in[100] = 1'b1;
    wait_msg(50, "R7 first grant at or above 41");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(msg_valid && msg_data == exp_data(50), "R8 stall hold",
            {31'(0), msg_valid, msg_data}, {32'(1), exp_data(50)});
    end
    msg_ready = 1'b1;
    wait_msg(100, "R7 second grant");
    wait_msg(3, "R7 wrap grant");
    expect_quiet(3, "R7 all drained");
    pins_in = '0;
    for (int w = 0; w < 4; w++) bus_write(16'(32'hA000 + 4 * w), 32'hFFFF_FFFF);
    expect_quiet(3, "R6 final quiet");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule